// File: doc/BRIEF.md
# Dithered Reload Period Sequencer

This block sits beside a timer's up-counter and supplies the reload value that ends each counting period. In plain mode it passes the low 16 bits of a 20-bit reload word straight through. In dither mode the word carries a 16-bit integer reload and a 4-bit fraction in sixteenths. Across a repeating frame of 16 periods, the block adds one extra clock to exactly as many periods as the fraction counts. This gives the average period a resolution of one sixteenth of a clock while each single period stays an integer length.

The counter pulses `period_end` in the cycle where it wraps. On that edge the sequencer steps its frame slot and latches the reload for the period that starts. While the counter is stopped, the sequencer sits in slot 0 and keeps loading the reload for slot 0, so the first period after enable already has the right length. The slot that receives the increment follows a bit-reversed ordering, which spreads the extra clocks as evenly as the frame allows.

Top module: `dither_reload_seq`

## Requirements
- R1: During reset (`rst_n` low at a clock edge), `period_idx` becomes 0 and `eff_reload` becomes 0.
- R2: With `dith_en` low, `eff_reload` loads `reload_word[15:0]` at each load point and bits 19:16 are ignored. A load point is any edge where `cnt_en` is low or `period_end` is high.
- R3: With `dith_en` high, the integer part is `reload_word[19:4]` and the fraction n is `reload_word[3:0]`. Slot i gets `integer+1` when the 4-bit bit-reversal of i is less than n, and `integer` otherwise.
- R4: In dither mode, exactly n of the 16 periods of every frame get the +1.
- R5: Periods are numbered 1..16, and period k uses slot k-1. Fraction 1 puts the +1 on period 1. Fraction 2 uses periods 1 and 9. Fraction 3 uses 1, 5 and 9. Fraction 4 uses 1, 5, 9 and 13. Fraction 8 uses every odd period. Fraction 15 uses every period but 16.
- R6: While `cnt_en` and `dith_en` are high, `period_idx` advances by one on each edge where `period_end` is high, and wraps from 15 to 0.
- R7: `period_idx` is 0 after any edge where `cnt_en` or `dith_en` is low.
- R8: While `cnt_en` is high, `eff_reload` changes only at an edge where `period_end` is high. A change of `reload_word` during a period therefore never alters that period.
- R9: While `cnt_en` is low, `eff_reload` is reloaded on every edge with the value for slot 0, one cycle after the inputs.
- R10: In dither mode, a reload word above 0xFFFEF is treated as 0xFFFEF (integer 65534, fraction 15). Slot 0 then gives 0xFFFF and slot 15 gives 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reload_word | input | 20 | Reload word: plain 16-bit value, or integer in 19:4 plus fraction in 3:0 |
| dith_en | input | 1 | Dither mode select; changed only while `cnt_en` is low |
| cnt_en | input | 1 | Counter running |
| period_end | input | 1 | One-cycle pulse from the counter at the end of a period |
| eff_reload | output | 16 | Reload value for the period in progress |
| period_idx | output | 4 | Frame slot of the period in progress (0..15) |

## Verification
A frame slot that is off by one moves the increment to the wrong periods. This shows on `eff_reload` within the first period after enable for fractions such as 1 or 15, because slot 0 and slot 15 differ there. A reload latch that opens mid-period shows within one cycle as an `eff_reload` change without `period_end`. A wrong bit-reversal or comparison shows within one 16-period frame as an increment count or placement that differs from the fraction. A missing clamp shows at the first load of an oversized word as 0x0000 in place of 0xFFFF.

// File: rtl/dither_reload_pkg.sv
// Shared sizing for the dithered reload sequencer.
// Assumes a 16-bit integer reload and a 4-bit fraction, giving a 16-slot frame.
package dither_reload_pkg;
    localparam int unsigned INT_W  = 16;
    localparam int unsigned FRAC_W = 4;
    localparam int unsigned WORD_W = INT_W + FRAC_W;
    localparam int unsigned SLOTS  = 1 << FRAC_W;
endpackage

// File: rtl/dither_slot_counter.sv
// Frame slot counter: steps once per period end while dithering runs.
// Assumes period_end is a single-cycle pulse. It returns to slot 0 whenever
// the counter is stopped or dithering is off. slot_nxt is the slot for the
// period that begins at the coming edge.
module dither_slot_counter #(
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dith_en,
    input  logic              period_end,
    output logic [FRAC_W-1:0] slot_q,
    output logic [FRAC_W-1:0] slot_nxt
);
    // next slot: cleared when idle, stepped (with natural wrap) at period end
    always_comb begin
        if (!run || !dith_en)
            slot_nxt = '0;
        else if (period_end)
            slot_nxt = slot_q + 1'b1;
        else
            slot_nxt = slot_q;
    end

    // slot register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else
            slot_q <= slot_nxt;
    end

    // R6: each period end while dithering runs advances the slot by one
    a_r6_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dith_en && period_end) |=> (slot_q == FRAC_W'($past(slot_q) + 1'b1)));

    // R7: a stopped counter or plain mode leaves the slot at zero
    a_r7_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !dith_en) |=> (slot_q == '0));
endmodule

// File: rtl/dither_slot_pattern.sv
// Spreading pattern: decides whether a slot receives the extra clock.
// The slot number is bit-reversed and compared with the fraction. This puts
// exactly 'frac' increments in each frame and spaces them as evenly as the
// frame allows. Purely combinational.
module dither_slot_pattern #(
    parameter int unsigned FRAC_W = 4
) (
    input  logic [FRAC_W-1:0] slot,
    input  logic [FRAC_W-1:0] frac,
    output logic              bump
);
    logic [FRAC_W-1:0] slot_rev;

    // wire-level bit reversal of the slot number
    for (genvar b = 0; b < FRAC_W; b++) begin : g_rev
        assign slot_rev[b] = slot[FRAC_W-1-b];
    end

    // extra clock when the reversed slot ranks below the fraction
    assign bump = (slot_rev < frac);
endmodule

// File: rtl/dither_reload_calc.sv
// Reload arithmetic: splits the word, clamps oversized dither words, and adds
// the pattern's extra clock. In plain mode the low integer bits pass through.
// Assumes the clamped integer never exceeds all-ones minus one, so +1 cannot
// overflow.
module dither_reload_calc #(
    parameter int unsigned INT_W  = 16,
    parameter int unsigned FRAC_W = 4
) (
    input  logic [INT_W+FRAC_W-1:0] word,
    input  logic                    dith_en,
    input  logic [FRAC_W-1:0]       slot,
    output logic [INT_W-1:0]        reload
);
    localparam int unsigned WORD_W = INT_W + FRAC_W;
    localparam logic [INT_W-1:0]  INT_MAX  = {{(INT_W-1){1'b1}}, 1'b0};
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;

    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic              bump;

    // clamp: an all-ones integer field becomes the largest accepted word
    always_comb begin
        if (word[WORD_W-1:FRAC_W] == '1) begin
            int_part  = INT_MAX;
            frac_part = FRAC_MAX;
        end else begin
            int_part  = word[WORD_W-1:FRAC_W];
            frac_part = word[FRAC_W-1:0];
        end
    end

    dither_slot_pattern #(.FRAC_W(FRAC_W)) u_pattern (
        .slot (slot),
        .frac (frac_part),
        .bump (bump)
    );

    // select plain value or dithered integer plus the slot's extra clock
    always_comb begin
        if (dith_en)
            reload = int_part + INT_W'(bump);
        else
            reload = word[INT_W-1:0];
    end
endmodule

// File: rtl/dither_reload_seq.sv
// Dithered reload period sequencer (top).
// Holds the reload for the period in progress and reloads it only at a period
// start: each period_end, or every cycle while the counter is stopped, so the
// first period after enable is ready. Assumes dith_en changes only while
// cnt_en is low and that period_end lasts one cycle.
module dither_reload_seq
    import dither_reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] reload_word,
    input  logic              dith_en,
    input  logic              cnt_en,
    input  logic              period_end,
    output logic [INT_W-1:0]  eff_reload,
    output logic [FRAC_W-1:0] period_idx
);
    logic [FRAC_W-1:0] slot_nxt;
    logic [INT_W-1:0]  reload_nxt;
    logic              load_pt;

    dither_slot_counter #(.FRAC_W(FRAC_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (cnt_en),
        .dith_en    (dith_en),
        .period_end (period_end),
        .slot_q     (period_idx),
        .slot_nxt   (slot_nxt)
    );

    dither_reload_calc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_calc (
        .word    (reload_word),
        .dith_en (dith_en),
        .slot    (slot_nxt),
        .reload  (reload_nxt)
    );

    // a new period starts at period end, or is pending while stopped
    assign load_pt = !cnt_en || period_end;

    // effective reload register, written only at a period start
    always_ff @(posedge clk) begin
        if (!rst_n)
            eff_reload <= '0;
        else if (load_pt)
            eff_reload <= reload_nxt;
    end

    // R8: a running period keeps its reload until the period ends
    a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !period_end) |=> $stable(eff_reload));

    // R2: plain mode loads the low half of the word at a load point
    a_r2_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!dith_en && (!cnt_en || period_end)) |=> (eff_reload == $past(reload_word[INT_W-1:0])));

    // R3: a dithered load stays within one clock above the integer part
    a_r3_within_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dith_en && period_end && cnt_en && (reload_word[WORD_W-1:FRAC_W] != '1))
        |=> ((eff_reload == $past(reload_word[WORD_W-1:FRAC_W])) ||
             (eff_reload == INT_W'($past(reload_word[WORD_W-1:FRAC_W]) + 1'b1))));

    // R9: a stopped counter always presents slot 0 on the index
    a_r9_stopped_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en) |=> (period_idx == '0));
endmodule

// File: tb/dither_reload_seq_bench.sv
// Bench: directed frame checks per fraction plus seeded random stimulus,
// compared with a cycle model built from the requirements.
module dither_reload_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] reload_word = '0;
    logic        dith_en = 1'b0;
    logic        cnt_en = 1'b0;
    logic        period_end = 1'b0;
    logic [15:0] eff_reload;
    logic [3:0]  period_idx;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0]  m_idx = '0;
    logic [15:0] m_eff = '0;

    always #5 clk = ~clk;

    dither_reload_seq u_dither_reload_seq (
        .clk(clk), .rst_n(rst_n), .reload_word(reload_word), .dith_en(dith_en),
        .cnt_en(cnt_en), .period_end(period_end),
        .eff_reload(eff_reload), .period_idx(period_idx)
    );

    // expected reload from R2, R3 and R10
    function automatic logic [15:0] exp_reload(logic [19:0] w, logic d, logic [3:0] i);
        logic [15:0] ip;
        logic [3:0]  fr, rv;
        if (!d) return w[15:0];
        ip = w[19:4]; fr = w[3:0];
        if (ip == 16'hFFFF) begin ip = 16'hFFFE; fr = 4'hF; end
        for (int b = 0; b < 4; b++) rv[b] = i[3-b];
        return ip + ((rv < fr) ? 16'd1 : 16'd0);
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at falling edge, update model, compare after rise
    task automatic step(logic [19:0] w, logic d, logic en, logic pe, string tag);
        @(negedge clk);
        reload_word = w; dith_en = d; cnt_en = en; period_end = pe;
        @(posedge clk);
        if (!en || !d) m_idx = '0;
        else if (pe) m_idx = m_idx + 4'd1;
        if (!en || pe) m_eff = exp_reload(w, d, m_idx);
        #2;
        check({tag, " idx"}, {12'h0, period_idx}, {12'h0, m_idx});
        check({tag, " reload"}, eff_reload, m_eff);
    endtask

    // run one frame at a given fraction; compare with the listed placements
    task automatic frame(logic [15:0] ip, logic [3:0] fr, logic [15:0] mask);
        logic [19:0] w;
        int ups;
        w = {ip, fr};
        ups = 0;
        step(w, 1'b1, 1'b0, 1'b0, "R9 stopped");
        for (int k = 0; k < 16; k++) begin
            check("R5 placement", eff_reload, ip + {15'h0, mask[k]});
            if (eff_reload == ip + 16'd1) ups++;
            step(w, 1'b1, 1'b1, 1'b0, "R3 run");
            step(w, 1'b1, 1'b1, 1'b1, "R6 step");
        end
        check("R4 count per frame", 16'(ups), {12'h0, fr});
        check("R6 wrap to slot 0", {12'h0, period_idx}, 16'h0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        reload_word = 20'hABCDE; dith_en = 1'b1; cnt_en = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset idx", {12'h0, period_idx}, 16'h0);
        check("R1 reset reload", eff_reload, 16'h0);
        rst_n = 1'b1;
        m_idx = '0; m_eff = '0;

        // R2: plain mode passes bits 15:0 and ignores 19:16
        step(20'hF1234, 1'b0, 1'b0, 1'b0, "R2 plain");
        check("R2 plain low bits", eff_reload, 16'h1234);
        step(20'h01234, 1'b0, 1'b1, 1'b1, "R2 plain");
        step(20'h05678, 1'b0, 1'b1, 1'b1, "R2 plain");
        check("R2 plain period", eff_reload, 16'h5678);

        // R5: placements for the listed fractions
        frame(16'd40, 4'd1,  16'h0001);
        frame(16'd40, 4'd2,  16'h0101);
        frame(16'd40, 4'd3,  16'h0111);
        frame(16'd40, 4'd4,  16'h1111);
        frame(16'd12, 4'd8,  16'h5555);
        frame(16'd12, 4'd15, 16'h7FFF);
        frame(16'd7,  4'd0,  16'h0000);

        // R8: a mid-period word change leaves the running period alone
        step(20'h00283, 1'b1, 1'b0, 1'b0, "R8 setup");
        step(20'h00283, 1'b1, 1'b1, 1'b0, "R8 run");
        step(20'h09990, 1'b1, 1'b1, 1'b0, "R8 change");
        check("R8 hold", eff_reload, 16'd41);
        step(20'h09990, 1'b1, 1'b1, 1'b1, "R8 new period");
        check("R8 next period", eff_reload, 16'h0999);

        // R10: oversized word clamps to integer 65534, fraction 15
        step(20'hFFFFF, 1'b1, 1'b0, 1'b0, "R10 clamp");
        check("R10 slot0", eff_reload, 16'hFFFF);
        for (int k = 0; k < 15; k++) step(20'hFFFFF, 1'b1, 1'b1, 1'b1, "R10 clamp");
        check("R10 slot15", eff_reload, 16'hFFFE);

        // R7: stopping the counter returns the slot to 0
        step(20'h00283, 1'b1, 1'b0, 1'b0, "R7 stop");
        check("R7 idx cleared", {12'h0, period_idx}, 16'h0);

        // random traffic; dither mode changes only while stopped
        begin
            logic [19:0] w;
            logic d, en;
            w = 20'h00100; d = 1'b1; en = 1'b0;
            for (int c = 0; c < 4000; c++) begin
                if (($urandom % 40) == 0) en = ~en;
                if (!en && (($urandom % 4) == 0)) d = ~d;
                if (($urandom % 8) == 0) w = 20'($urandom);
                step(w, d, en, (($urandom % 3) == 0), "R3 random");
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule